// File: doc/BRIEF.md
# Interrupt Claim-Complete Controller

This block collects interrupt requests from a small set of sources and presents them to one target context. Each source has a pending flag, an enable bit and a priority. The target has a priority threshold. The target is interrupted whenever some enabled, pending source has a priority above the threshold. Software then reads a single claim/complete register to learn which source to service. That read also takes the source out of the pending state and holds it "in service". When the handler is done, software writes the source number back into the same register.

A source that is in service is masked: a new rising edge on its input is dropped until the source is completed. The completion is checked only against the enable bit, not against the ID that was last claimed. A completion for a source whose enable is clear at that moment does nothing. A source disabled during service therefore stays in service, and its later edges are lost, until it is re-enabled and completed.

Access uses a word-addressed register port with valid/ready signalling. The port is always ready. Every accepted read returns its data on the next cycle.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset the enables, the threshold and all priorities read as 0. No source is pending or in service, `irq_o` is low and a claim read returns 0.
- R2: A low-to-high change on `src_i[k-1]` sets the pending flag of source ID k only if that source is neither pending nor in service at that edge. A source is never pending and in service at once.
- R3: A claim read returns the ID of the source with the highest priority among those that are pending, enabled and above the threshold. On equal priority the lowest ID wins. It returns 0 when no source qualifies.
- R4: A claim read that returns ID k clears pending for k and marks k in service in the same cycle. Every accepted read gives `rsp_valid` high with its data one cycle later.
- R5: `irq_o` is high exactly when some source is pending, enabled, not in service and has priority strictly greater than the threshold.
- R6: Writing ID k to the claim/complete word ends service of k when k is enabled, whichever ID was claimed last. A later rising edge then makes k pending again.
- R7: A completion write is ignored if the ID is 0, is greater than the number of sources, or names a source whose enable bit is 0 at that write. An ignored completion leaves the source in service, so its new edges are still dropped.
- R8: A source with priority 0 never raises `irq_o` and is never returned by a claim read.
- R9: Register words: word 0 holds the enables, with bit k enabling source ID k and bit 0 always reading 0. Word 1 holds the threshold, word 2 is claim/complete, and word 3+k holds the priority of source ID k. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Source request lines; bit k-1 belongs to source ID k |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted (always high) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W | Read data |
| irq_o | output | 1 | Interrupt request to the target |

## Verification
Claim reads are tried with a single pending source and with two sources of equal priority, which tells tie ordering apart from plain selection. They are also tried with three sources of distinct priority raised in the same cycle, which shows whether the ranking is by priority rather than by ID. Sources whose priority is 0 or equal to the threshold are raised to separate the "strictly above" rule from "at or above". Completions are sent out of claim order, with ID 0, with out-of-range IDs and for a disabled source. After each, the source is pulsed again to show from the next claim whether it is still held in service.

// File: rtl/irq_cc_pkg.sv
`timescale 1ns/1ps
package irq_cc_pkg;

    // Word offsets of the register port
    localparam int unsigned OFS_ENABLE    = 0;
    localparam int unsigned OFS_THRESH    = 1;
    localparam int unsigned OFS_CLAIM     = 2;
    localparam int unsigned OFS_PRIO_BASE = 3;   // source k lives at base + k

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_THRESH,
        SEL_CLAIM,
        SEL_PRIO
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e decode_sel(input int unsigned word,
                                            input int unsigned nsrc);
        if (word == OFS_ENABLE)                       return SEL_ENABLE;
        if (word == OFS_THRESH)                       return SEL_THRESH;
        if (word == OFS_CLAIM)                        return SEL_CLAIM;
        if (word > OFS_PRIO_BASE && word <= OFS_PRIO_BASE + nsrc)
                                                      return SEL_PRIO;
        return SEL_NONE;
    endfunction

    function automatic bus_op_t decode_op(input logic valid, input logic write,
                                          input int unsigned word,
                                          input int unsigned nsrc);
        bus_op_t op;
        op.rd  = valid & ~write;
        op.wr  = valid & write;
        op.sel = decode_sel(word, nsrc);
        return op;
    endfunction

endpackage

// File: rtl/irq_cc_regs.sv
`timescale 1ns/1ps
module irq_cc_regs
    import irq_cc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ID_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          req_ready,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    input  logic [ID_W-1:0]               claim_id,
    output logic                          claim_take,
    output logic                          done_valid,
    output logic [ID_W-1:0]               done_id,
    output logic [NUM_SRC:0]              en_o,
    output logic [PRIO_W-1:0]             thr_o,
    output logic [NUM_SRC:0][PRIO_W-1:0]  prio_o
);

    localparam int unsigned PIDX_W = ADDR_W;

    bus_op_t              op;
    logic [PIDX_W-1:0]    pidx;
    logic [NUM_SRC:0]     en_q;
    logic [PRIO_W-1:0]    thr_q;
    logic [NUM_SRC:0][PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0]    rd_data;
    logic                 id_in_range;

    assign req_ready = 1'b1;
    assign op        = decode_op(req_valid, req_write, 32'(req_addr), NUM_SRC);
    assign pidx      = req_addr - PIDX_W'(OFS_PRIO_BASE);

    assign id_in_range = (req_wdata != '0) && (req_wdata <= DATA_W'(NUM_SRC));
    assign claim_take  = op.rd && (op.sel == SEL_CLAIM);
    assign done_valid  = op.wr && (op.sel == SEL_CLAIM) && id_in_range;
    assign done_id     = req_wdata[ID_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            thr_q <= '0;
        end else if (op.wr) begin
            if (op.sel == SEL_ENABLE) en_q  <= {req_wdata[NUM_SRC:1], 1'b0};
            if (op.sel == SEL_THRESH) thr_q <= req_wdata[PRIO_W-1:0];
        end
    end

    assign prio_q[0] = '0;

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[k] <= '0;
            end else if (op.wr && op.sel == SEL_PRIO && pidx == PIDX_W'(k)) begin
                prio_q[k] <= req_wdata[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (op.sel)
            SEL_ENABLE: rd_data[NUM_SRC:0] = en_q;
            SEL_THRESH: rd_data[PRIO_W-1:0] = thr_q;
            SEL_CLAIM:  rd_data[ID_W-1:0]   = claim_id;
            SEL_PRIO: begin
                for (int k = 1; k <= NUM_SRC; k++) begin
                    if (pidx == PIDX_W'(k)) rd_data[PRIO_W-1:0] = prio_q[k];
                end
            end
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= op.rd;
            rsp_rdata <= op.rd ? rd_data : '0;
        end
    end

    assign en_o   = en_q;
    assign thr_o  = thr_q;
    assign prio_o = prio_q;

endmodule

// File: rtl/irq_cc_gateway.sv
`timescale 1ns/1ps
module irq_cc_gateway #(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC:0]   en_i,
    input  logic               claim_take,
    input  logic [ID_W-1:0]    claim_id,
    input  logic               done_valid,
    input  logic [ID_W-1:0]    done_id,
    output logic [NUM_SRC:0]   pend_o,
    output logic [NUM_SRC:0]   ins_o
);

    assign pend_o[0] = 1'b0;
    assign ins_o[0]  = 1'b0;

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
        logic src_q;
        logic pend_q;
        logic ins_q;
        logic rise;
        logic take;
        logic fin;

        assign rise = src_i[k-1] & ~src_q;
        assign take = claim_take && (claim_id == ID_W'(k));
        assign fin  = done_valid && (done_id == ID_W'(k)) && en_i[k];

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q  <= 1'b0;
                pend_q <= 1'b0;
                ins_q  <= 1'b0;
            end else begin
                src_q <= src_i[k-1];
                if (take) begin
                    pend_q <= 1'b0;
                end else if (rise && !pend_q && !ins_q) begin
                    pend_q <= 1'b1;
                end
                if (take) begin
                    ins_q <= 1'b1;
                end else if (fin) begin
                    ins_q <= 1'b0;
                end
            end
        end

        assign pend_o[k] = pend_q;
        assign ins_o[k]  = ins_q;
    end

endmodule

// File: rtl/irq_cc_arbiter.sv
`timescale 1ns/1ps
module irq_cc_arbiter #(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ID_W    = 3
) (
    input  logic [NUM_SRC:0]              pend_i,
    input  logic [NUM_SRC:0]              ins_i,
    input  logic [NUM_SRC:0]              en_i,
    input  logic [NUM_SRC:0][PRIO_W-1:0]  prio_i,
    input  logic [PRIO_W-1:0]             thr_i,
    output logic [ID_W-1:0]               best_id,
    output logic                          any_o
);

    logic [NUM_SRC:0] elig;
    logic [PRIO_W-1:0] best_p;

    assign elig[0] = 1'b0;
    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_elig
        assign elig[k] = pend_i[k] & en_i[k] & ~ins_i[k] & (prio_i[k] > thr_i);
    end

    assign any_o = |elig;

    // Strict compare keeps the lower ID on equal priority
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            if (elig[k] && prio_i[k] > best_p) begin
                best_id = ID_W'(k);
                best_p  = prio_i[k];
            end
        end
    end

endmodule

// File: rtl/irq_claim_ctrl.sv
`timescale 1ns/1ps
module irq_claim_ctrl
    import irq_cc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               irq_o
);

    localparam int unsigned ID_W = $clog2(NUM_SRC + 1);

    if (OFS_PRIO_BASE + NUM_SRC >= (1 << ADDR_W)) begin : g_bad_addr
        $error("ADDR_W too small for NUM_SRC priority words");
    end
    if (DATA_W <= NUM_SRC || DATA_W < PRIO_W) begin : g_bad_data
        $error("DATA_W too small");
    end

    logic [NUM_SRC:0]             en_vec;
    logic [PRIO_W-1:0]            thr;
    logic [NUM_SRC:0][PRIO_W-1:0] prio;
    logic [NUM_SRC:0]             pend_vec;
    logic [NUM_SRC:0]             ins_vec;
    logic [ID_W-1:0]              best_id;
    logic                         any_elig;
    logic                         claim_take;
    logic                         done_valid;
    logic [ID_W-1:0]              done_id;

    irq_cc_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .ID_W(ID_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .claim_id   (best_id),
        .claim_take (claim_take),
        .done_valid (done_valid),
        .done_id    (done_id),
        .en_o       (en_vec),
        .thr_o      (thr),
        .prio_o     (prio)
    );

    irq_cc_gateway #(
        .NUM_SRC(NUM_SRC), .ID_W(ID_W)
    ) u_gw (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .en_i       (en_vec),
        .claim_take (claim_take),
        .claim_id   (best_id),
        .done_valid (done_valid),
        .done_id    (done_id),
        .pend_o     (pend_vec),
        .ins_o      (ins_vec)
    );

    irq_cc_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_arb (
        .pend_i  (pend_vec),
        .ins_i   (ins_vec),
        .en_i    (en_vec),
        .prio_i  (prio),
        .thr_i   (thr),
        .best_id (best_id),
        .any_o   (any_elig)
    );

    assign irq_o = any_elig;

endmodule

module irq_cc_checker
    import irq_cc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_o,
    input logic [NUM_SRC:0]  pend_vec,
    input logic [NUM_SRC:0]  ins_vec,
    input logic [NUM_SRC:0]  en_vec
);
    localparam int unsigned IW = $clog2(NUM_SRC + 1);

    logic          is_claim_rd;
    logic          is_claim_wr;
    logic [IW-1:0] wid;
    logic [IW-1:0] rid;
    logic          wid_ok;

    assign is_claim_rd = req_valid && !req_write && req_addr == ADDR_W'(OFS_CLAIM);
    assign is_claim_wr = req_valid && req_write && req_addr == ADDR_W'(OFS_CLAIM);
    assign wid    = req_wdata[IW-1:0];
    assign rid    = rsp_rdata[IW-1:0];
    assign wid_ok = req_wdata != '0 && req_wdata <= DATA_W'(NUM_SRC);

    assert_pend_ins_disjoint_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & ins_vec) == '0);

    assert_read_response_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_claim_marks_service_R4: assert property (@(posedge clk) disable iff (rst)
        (is_claim_rd && irq_o) |=> (rsp_rdata != '0 && ins_vec[rid] && !pend_vec[rid]));

    assert_claim_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (is_claim_rd && !irq_o) |=> rsp_rdata == '0);

    assert_irq_needs_enabled_pending_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_vec & en_vec) != '0);

    assert_disabled_done_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (is_claim_wr && wid_ok && !en_vec[wid] && ins_vec[wid]) |=> ins_vec[$past(wid)]);

endmodule

bind irq_claim_ctrl irq_cc_checker #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq_o     (irq_o),
    .pend_vec  (pend_vec),
    .ins_vec   (ins_vec),
    .en_vec    (en_vec)
);

// File: tb/sim_irq_claim_ctrl.sv
`timescale 1ns/1ps
module sim_irq_claim_ctrl;
    localparam int N  = 7;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    irq_claim_ctrl #(.NUM_SRC(N), .PRIO_W(3), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .src_i(src),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    // ---------------- behavioural reference ----------------
    int m_pend[N+1], m_ins[N+1], m_en[N+1], m_prio[N+1], m_srcq[N+1];
    int m_thr, m_rv, m_rd;

    function automatic int m_best();
        int b = 0, bp = 0;
        for (int k = 1; k <= N; k++)
            if (m_pend[k] != 0 && m_en[k] != 0 && m_ins[k] == 0 &&
                m_prio[k] > m_thr && m_prio[k] > bp) begin
                b = k; bp = m_prio[k];
            end
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= N; k++) begin
                m_pend[k] = 0; m_ins[k] = 0; m_en[k] = 0; m_prio[k] = 0; m_srcq[k] = 0;
            end
            m_thr = 0; m_rv = 0; m_rd = 0;
        end else begin
            int best, a, old_p[N+1], old_i[N+1];
            best = m_best();
            for (int k = 1; k <= N; k++) begin old_p[k] = m_pend[k]; old_i[k] = m_ins[k]; end
            for (int k = 1; k <= N; k++) begin
                if (src[k-1] && m_srcq[k] == 0 && old_p[k] == 0 && old_i[k] == 0) m_pend[k] = 1;
                m_srcq[k] = src[k-1];
            end
            a = int'(req_addr);
            m_rv = (req_valid && !req_write) ? 1 : 0;
            m_rd = 0;
            if (req_valid && req_write) begin
                if (a == 0) for (int k = 1; k <= N; k++) m_en[k] = int'(req_wdata[k]);
                else if (a == 1) m_thr = int'(req_wdata[2:0]);
                else if (a == 2) begin
                    if (req_wdata >= 1 && req_wdata <= N && m_en[req_wdata] != 0)
                        m_ins[req_wdata] = 0;
                end else if (a >= 4 && a <= 3 + N) m_prio[a-3] = int'(req_wdata[2:0]);
            end else if (req_valid) begin
                if (a == 0) for (int k = 1; k <= N; k++) m_rd += m_en[k] << k;
                else if (a == 1) m_rd = m_thr;
                else if (a == 2) begin
                    m_rd = best;
                    if (best != 0) begin m_pend[best] = 0; m_ins[best] = 1; end
                end else if (a >= 4 && a <= 3 + N) m_rd = m_prio[a-3];
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge (R5, R4)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5 irq_o vs model", irq_o, m_best() != 0);
            check("R4 rsp_valid vs model", rsp_valid, m_rv);
            if (m_rv != 0) check("R4 rsp_rdata vs model", rsp_rdata, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input int a, input int d);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = DW'(d);
        tick();
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input int a, output int d);
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        tick();
        d = int'(rsp_rdata);
        req_valid = 0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        int d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // mask bit k-1 = source ID k
    task automatic pulse(input logic [N-1:0] m);
        src = src & ~m; tick();
        src = src | m;  tick();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        check("R1 irq_o low after reset", irq_o, 0);
        rd_chk(2, 0, "R1 claim after reset");
        rd_chk(0, 0, "R1 enable after reset");
        rd_chk(1, 0, "R1 threshold after reset");
        rd_chk(5, 0, "R1 priority after reset");

        // R9 register map
        wr(4, 2); wr(5, 5); wr(6, 5); wr(7, 0); wr(8, 1); wr(9, 3); wr(10, 7);
        wr(0, 'hFF); wr(1, 1);
        rd_chk(6, 5, "R9 priority of ID3 readback");
        rd_chk(0, 'hFE, "R9 enable readback, bit0 zero");
        rd_chk(1, 1, "R9 threshold readback");

        // R3 tie: IDs 2 and 3 share priority 5
        src[1] = 1; src[2] = 1; tick();
        check("R5 irq with two pending", irq_o, 1);
        rd_chk(2, 2, "R3 tie picks lower ID");
        rd_chk(2, 3, "R3 next claim");
        rd_chk(2, 0, "R3 none left");
        check("R5 irq low when all in service", irq_o, 0);

        // R2 edge while in service is dropped
        pulse(7'b0000010);
        rd_chk(2, 0, "R2 edge dropped while in service");

        // R6 complete out of claim order
        wr(2, 3);
        pulse(7'b0000100);
        rd_chk(2, 3, "R6 ID3 pending again after completion");

        // R8 priority zero, R3 threshold equal
        pulse(7'b0001000);
        check("R8 priority 0 no irq", irq_o, 0);
        rd_chk(2, 0, "R8 priority 0 not claimed");
        pulse(7'b0010000);
        check("R3 priority equal to threshold no irq", irq_o, 0);
        wr(1, 0);
        check("R5 irq after threshold lowered", irq_o, 1);
        rd_chk(2, 5, "R3 claim once above threshold");
        rd_chk(2, 0, "R8 priority 0 still ignored at threshold 0");

        // R7 completion of a disabled source
        wr(0, 'hFA); wr(2, 2); wr(0, 'hFE);
        pulse(7'b0000010);
        rd_chk(2, 0, "R7 disabled completion left ID2 in service");
        wr(2, 2);
        pulse(7'b0000010);
        rd_chk(2, 2, "R6 enabled completion frees ID2");

        // R7 ID 0 and out of range
        wr(2, 0); wr(2, 9); wr(2, 15);
        pulse(7'b0010000);
        rd_chk(2, 0, "R7 bad IDs left ID5 in service");
        wr(2, 5);
        pulse(7'b0010000);
        rd_chk(2, 5, "R6 ID5 freed");

        // R3 ranking by priority: IDs 1 (2), 6 (3), 7 (7)
        pulse(7'b1100001);
        rd_chk(2, 7, "R3 highest priority first");
        rd_chk(2, 6, "R3 second priority");
        rd_chk(2, 1, "R3 third priority");
        rd_chk(2, 0, "R3 empty");

        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule